// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a bus master and memory. It turns single bits of a backing memory region into separate 32-bit words in a larger alias window. There are two alias windows, and each one points at its own backing base. Each aligned alias word stands for one bit of backing memory. A read of that word returns the bit as 0 or 1. A write to that word sets or clears only that bit. The write is done as a locked read-modify-write on the memory side.

The slave port takes one request at a time. The request holds until `s_ready` pulses for one cycle. The master port raises `m_req` and holds the address, size, direction and data stable until memory answers with `m_ready`. An address outside both windows is forwarded to memory unchanged, as a single transaction. Byte, halfword and word access sizes are supported. The size picks which backing location is touched and how many bit positions the alias address can select.

Top module: `bitband_bridge`

## Requirements
- R1: An address is an alias access when its upper bits `[31:25]` match a window start (window 0 at 0x2200_0000, window 1 at 0x4200_0000). Its backing byte address is the window's backing base (0x2000_0000 or 0x4000_0000) OR'd with bits `[24:5]` of the address shifted down by 5.
- R2: A byte access is coded as size 0. It uses address bits `[4:2]` as the bit number and leaves the backing address unaligned.
- R3: A halfword access is coded as size 1. It uses address bits `[5:2]` as the bit number and clears bit 0 of the backing address.
- R4: A word access is coded as size 2. It uses address bits `[6:2]` as the bit number and clears bits 1:0 of the backing address.
- R5: An alias read makes exactly one unlocked master read at the access size. Bit 0 of `s_rdata` is the selected backing bit, and bits 31:1 are zero.
- R6: An alias write makes a master read and then a master write to the same address and size. The written data equals the read data with the selected bit replaced by `s_wdata[0]`. The other bits within the size are unchanged, and the bits above the size are zero. Bits 31:1 of `s_wdata` have no effect.
- R7: `m_lock` is high during both master phases of an alias write. It is low for alias reads, for pass-through accesses, and once the write-back has completed.
- R8: A non-alias access makes one unlocked master transaction with the address, size, direction and write data unchanged. A read returns `m_rdata` on `s_rdata` unchanged.
- R9: `s_ready` is a one-cycle pulse. It comes in the cycle after the clock edge on which the final master phase completes. `m_req` and its address and direction stay stable while `m_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Slave request, held until `s_ready` |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| s_addr | input | 32 | Slave byte address |
| s_wdata | input | 32 | Slave write data |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result, valid with `s_ready` |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_lock | output | 1 | Master lock over a read-modify-write |
| m_size | output | 2 | Master access size |
| m_addr | output | 32 | Master byte address |
| m_wdata | output | 32 | Master write data, right-justified |
| m_ready | input | 1 | Memory completes the current phase |
| m_rdata | input | 32 | Memory read data, right-justified, valid with `m_ready` |

## Verification
A request is registered on the first edge where it is seen. `m_req` rises after that edge. Each master phase ends on the edge where `m_ready` is high. The memory model inserts 0 to 2 wait cycles, which vary from case to case. The bench records the cycle number of the last master handshake. It then requires `s_ready` to be first seen at the falling edge one cycle later, and to be gone at the next falling edge. The master transactions of every access are logged at their handshake edges and compared after `s_ready`. So the address, size, lock and data are checked exactly where the memory captured them. The expected values come from the window and bit arithmetic and from the bench's own memory contents.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] ALIAS0  = 32'h2200_0000,
  parameter logic [31:0] BASE0   = 32'h2000_0000,
  parameter logic [31:0] ALIAS1  = 32'h4200_0000,
  parameter logic [31:0] BASE1   = 32'h4000_0000,
  parameter int          SPAN_LG = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_req,
  input  logic        s_we,
  input  logic [1:0]  s_size,
  input  logic [31:0] s_addr,
  input  logic [31:0] s_wdata,
  output logic        s_ready,
  output logic [31:0] s_rdata,
  output logic        m_req,
  output logic        m_we,
  output logic        m_lock,
  output logic [1:0]  m_size,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  input  logic        m_ready,
  input  logic [31:0] m_rdata
);
  localparam logic [31:0] OFF_MASK = (32'd1 << SPAN_LG) - 32'd1;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_STORE, ST_PASS, ST_DONE} st_t;
  st_t st;

  logic [31:0] r_addr, r_wdata, r_rdata;
  logic [1:0]  r_size;
  logic [4:0]  r_bit;
  logic        r_we, r_set, r_alias;

  function automatic logic [31:0] size_mask(logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  wire        hit0    = s_addr[31:SPAN_LG] == ALIAS0[31:SPAN_LG];
  wire        hit1    = s_addr[31:SPAN_LG] == ALIAS1[31:SPAN_LG];
  wire        is_word = s_size[1];
  wire        is_half = s_size == 2'd1;
  wire [31:0] raw_bk  = (hit0 ? BASE0 : BASE1) | ((s_addr & OFF_MASK) >> 5);
  wire [31:0] bk_addr = raw_bk & ~{30'd0, is_word, is_word | is_half};
  wire [4:0]  bk_bit  = s_addr[6:2] & {is_word, is_word | is_half, 3'b111};

  wire        hs      = m_req && m_ready;
  wire [31:0] bmask   = 32'd1 << r_bit;
  wire [31:0] merged  = (m_rdata & size_mask(r_size) & ~bmask) | (r_set ? bmask : 32'd0);

  assign m_req   = (st == ST_FETCH) || (st == ST_STORE) || (st == ST_PASS);
  assign m_we    = (st == ST_STORE) || ((st == ST_PASS) && r_we);
  assign m_lock  = (st == ST_STORE) || ((st == ST_FETCH) && r_we);
  assign m_addr  = r_addr;
  assign m_size  = r_size;
  assign m_wdata = r_wdata;
  assign s_ready = st == ST_DONE;
  assign s_rdata = r_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      r_addr  <= '0;
      r_wdata <= '0;
      r_rdata <= '0;
      r_size  <= '0;
      r_bit   <= '0;
      r_we    <= 1'b0;
      r_set   <= 1'b0;
      r_alias <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (s_req) begin
          r_we    <= s_we;
          r_size  <= s_size;
          r_alias <= hit0 || hit1;
          r_set   <= s_wdata[0];
          r_bit   <= bk_bit;
          if (hit0 || hit1) begin
            r_addr <= bk_addr;
            st     <= ST_FETCH;
          end else begin
            r_addr  <= s_addr;
            r_wdata <= s_wdata;
            st      <= ST_PASS;
          end
        end
        ST_FETCH: if (hs) begin
          if (r_we) begin
            r_wdata <= merged;
            st      <= ST_STORE;
          end else begin
            r_rdata <= {31'd0, m_rdata[r_bit]};
            st      <= ST_DONE;
          end
        end
        ST_STORE: if (hs) begin
          r_rdata <= '0;
          st      <= ST_DONE;
        end
        ST_PASS: if (hs) begin
          r_rdata <= m_rdata;
          st      <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  rmw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ready && m_lock && !m_we) |=> (m_req && m_we && m_lock));
  // R7
  unlock_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ready && m_lock && m_we) |=> !m_lock);
  // R6
  store_same_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ready && m_lock && !m_we) |=> ($stable(m_addr) && $stable(m_size)));
  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we)));
  // R5
  rd_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && r_alias && !r_we) |-> (s_rdata[31:1] == 31'd0));
  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && r_alias && m_size == 2'd2) |-> (m_addr[1:0] == 2'd0));
endmodule

// File: tb/sim_bitband_bridge.sv
`timescale 1ns/1ps
module sim_bitband_bridge;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, s_req, s_we, s_ready, m_req, m_we, m_lock, m_ready;
  logic [1:0]  s_size, m_size;
  logic [31:0] s_addr, s_wdata, s_rdata, m_addr, m_wdata, m_rdata;

  bitband_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .s_req(s_req), .s_we(s_we), .s_size(s_size), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_ready(s_ready), .s_rdata(s_rdata),
    .m_req(m_req), .m_we(m_we), .m_lock(m_lock), .m_size(m_size), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
  );

  int ntests = 0, nfail = 0, cyc = 0, last_hs = 0, lat = 0, wcnt = 0, nlog = 0;
  logic [31:0] log_addr [4];
  logic [31:0] log_wdata [4];
  logic [1:0]  log_size [4];
  logic        log_we [4];
  logic        log_lock [4];
  logic [7:0]  mem [logic [31:0]];

  function automatic logic [7:0] rdb(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16];
  endfunction

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] rdv(logic [31:0] a, logic [1:0] s);
    logic [31:0] v = '0;
    for (int i = 0; i < nbytes(s); i++) v[8*i +: 8] = rdb(a + i);
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_ready <= 1'b0;
      m_rdata <= '0;
      wcnt    <= 0;
    end else if (m_req && m_ready) begin
      if (m_we)
        for (int i = 0; i < nbytes(m_size); i++) mem[m_addr + i] = m_wdata[8*i +: 8];
      if (nlog < 4) begin
        log_addr[nlog]  = m_addr;
        log_wdata[nlog] = m_wdata;
        log_size[nlog]  = m_size;
        log_we[nlog]    = m_we;
        log_lock[nlog]  = m_lock;
      end
      nlog    = nlog + 1;
      last_hs = cyc;
      m_ready <= 1'b0;
      wcnt    <= 0;
    end else if (m_req) begin
      if (wcnt >= lat) begin
        m_ready <= 1'b1;
        m_rdata <= rdv(m_addr, m_size);
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
  endtask

  always @(posedge clk) if (cyc > 190000) begin
    nfail++;
    $display("FAIL watchdog act=%0d exp<190000", cyc);
    report();
    $finish;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int t = 0;
    @(negedge clk);
    nlog = 0;
    s_req = 1'b1; s_we = we; s_addr = a; s_size = sz; s_wdata = wd;
    do begin @(negedge clk); t++; end while (!s_ready && t < 300);
    if (!s_ready) chk(1'b0, "R9 timeout", 32'(t), 32'd0);
    rd = s_rdata;
    chk(cyc == last_hs + 1, "R9 ready timing", 32'(cyc), 32'(last_hs + 1));
    s_req = 1'b0;
    @(negedge clk);
    chk(!s_ready, "R9 ready pulse", 32'(s_ready), 32'd0);
    chk(!m_lock && !m_req, "R7 idle unlocked", {30'd0, m_lock, m_req}, 32'd0);
  endtask

  logic [31:0] aliases [2];
  logic [31:0] bases [2];
  logic [31:0] boffs [4];
  logic [31:0] pass_a [5];

  initial begin
    logic [31:0] rd, al, off, ea, old, nw, bm, wd;
    int eb;
    aliases[0] = 32'h2200_0000; aliases[1] = 32'h4200_0000;
    bases[0]   = 32'h2000_0000; bases[1]   = 32'h4000_0000;
    boffs[0] = 32'h0; boffs[1] = 32'h3; boffs[2] = 32'h6; boffs[3] = 32'hF_FFFF;
    pass_a[0] = 32'h21FF_FFFC; pass_a[1] = 32'h2400_0000; pass_a[2] = 32'h0000_1004;
    pass_a[3] = 32'h4400_0010; pass_a[4] = 32'h41FF_FFF0;
    rst_n = 1'b0; s_req = 1'b0; s_we = 1'b0; s_addr = '0; s_size = '0; s_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_ready && !m_req && !m_lock, "R9 reset state", {29'd0, s_ready, m_req, m_lock}, 32'd0);

    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int bi = 0; bi < 4; bi++)
          for (int k = 0; k < 32; k++) begin
            lat = (k + bi) % 3;
            al  = aliases[w] + ((boffs[bi] << 5) | (32'(k) << 2));
            off = al & 32'h01FF_FFFF;
            ea  = bases[w] | (off >> 5);
            if (sz == 1) ea = ea & ~32'd1;
            if (sz == 2) ea = ea & ~32'd3;
            eb  = int'((off >> 2) & ((32'd8 << sz) - 32'd1));
            old = rdv(ea, 2'(sz));
            bm  = 32'd1 << eb;
            // alias read: R1..R5
            access(1'b0, al, 2'(sz), 32'hFFFF_FFFF, rd);
            chk(rd == {31'd0, old[eb]}, "R5 read bit", rd, {31'd0, old[eb]});
            chk(nlog == 1 && !log_we[0] && !log_lock[0], "R5 single unlocked read",
                32'(nlog), 32'd1);
            chk(log_addr[0] == ea, sz == 0 ? "R2 byte addr" : sz == 1 ? "R3 half addr" : "R4 word addr",
                log_addr[0], ea);
            chk(log_size[0] == 2'(sz), "R1 size forwarded", 32'(log_size[0]), 32'(sz));
            // alias write: R6, R7
            wd = {(k % 2 == 1) ? 31'h7FFF_FFFF : 31'h2AAA_5555, ~old[eb]};
            nw = old[eb] ? (old & ~bm) : (old | bm);
            access(1'b1, al, 2'(sz), wd, rd);
            chk(nlog == 2, "R6 two phases", 32'(nlog), 32'd2);
            chk(!log_we[0] && log_we[1] && log_addr[1] == ea && log_size[1] == 2'(sz),
                "R6 rmw same location", log_addr[1], ea);
            chk(log_wdata[1] == nw, "R6 merged data", log_wdata[1], nw);
            chk(log_lock[0] && log_lock[1], "R7 lock both phases",
                {30'd0, log_lock[0], log_lock[1]}, 32'd3);
            access(1'b0, al, 2'(sz), 32'd0, rd);
            chk(rd == {31'd0, ~old[eb]}, "R6 readback", rd, {31'd0, ~old[eb]});
          end

    // pass-through: R8
    for (int p = 0; p < 5; p++) begin
      lat = p % 3;
      wd = 32'hA5C3_0F1E ^ pass_a[p];
      access(1'b1, pass_a[p], 2'd2, wd, rd);
      chk(nlog == 1 && log_we[0] && !log_lock[0], "R8 single write", 32'(nlog), 32'd1);
      chk(log_addr[0] == pass_a[p], "R8 addr unchanged", log_addr[0], pass_a[p]);
      chk(log_wdata[0] == wd, "R8 wdata unchanged", log_wdata[0], wd);
      access(1'b0, pass_a[p], 2'd2, 32'd0, rd);
      chk(nlog == 1 && !log_we[0] && !log_lock[0], "R8 single read", 32'(nlog), 32'd1);
      chk(rd == wd, "R8 read data", rd, wd);
      access(1'b0, pass_a[p] + 32'd1, 2'd0, 32'd0, rd);
      chk(log_addr[0] == pass_a[p] + 32'd1 && log_size[0] == 2'd0, "R8 byte addr/size",
          log_addr[0], pass_a[p] + 32'd1);
      chk(rd == {24'd0, wd[15:8]}, "R8 byte data", rd, {24'd0, wd[15:8]});
    end

    report();
    $finish;
  end
endmodule